// File: doc/BRIEF.md
# Recipe Command Sequencer

This block walks through the micro-commands that one recipe holds for a single execution unit and hands them to that unit one at a time. Commands sit in a local command store that is organised as a grid of recipes by command slots. A write port fills the store ahead of time. A start pulse names a recipe. The sequencer then fetches slot 0, slot 1 and so on, and for each slot it either issues the command, skips it or waits for the unit.

A command is 64 bits wide and is read as two 32-bit halves. In the lower half, bit 30 marks a command to be skipped and bit 31 is an immediate-operand flag that passes through unchanged. In the upper half, bit 32 marks the final command of the recipe and bit 33 marks a command that may only be issued while the unit reports ready. A unit that has no work in a recipe gets one command with both the final and the skip flags set, so the sequence ends at once. If none of the slots carries the final flag, the sequence stops after the last slot and raises an error flag.

Top module: `recipe_cmd_sequencer`

## Requirements
- R1: After reset the block is idle and `cmdValid`, `seqDone`, `noLastErr` and `busyReject` are all low.
- R2: A start pulse while idle latches `startRecipe` and visits slots in rising order from 0. Each slot takes one fetch cycle and then at least one execute cycle, so the first execute cycle is the second cycle after the start edge.
- R3: The command at store entry (recipe, slot) is presented on `cmdWord` exactly as written, with `cmdSlot` equal to its slot number. The command is issued (`cmdValid` high for one cycle) when bit 30 is clear and either bit 33 is clear or `unitReady` is high.
- R4: A command with bit 30 set is consumed in its execute cycle and is never issued, whatever the state of bit 33 and `unitReady`.
- R5: While a command with bit 33 set and bit 30 clear waits with `unitReady` low, `cmdValid` stays low and `cmdWord` and `cmdSlot` hold steady. The command is issued in the first cycle in which `unitReady` is high.
- R6: `seqDone` pulses for one cycle in the execute cycle of the first command that has bit 32 set, and the block is then idle. A command with both bit 32 and bit 30 set at slot 0 ends the sequence in its first execute cycle with no command issued.
- R7: If no command among the SLOTS slots has bit 32 set, `seqDone` and `noLastErr` pulse together in the execute cycle of the final slot.
- R8: A start pulse that arrives while a sequence is running raises `busyReject` in that same cycle and is otherwise ignored. The running sequence carries on unchanged.
- R9: A write goes to store entry `wrRecipe*SLOTS + wrSlot`. If a write lands in the same cycle as the fetch of that entry, the fetch returns the old command and the next fetch of that entry returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start pulse |
| startRecipe | input | 4 | Recipe to run |
| unitReady | input | 1 | The unit can accept a command that must wait for ready |
| wrEn | input | 1 | Store write enable |
| wrRecipe | input | 4 | Recipe of the store write |
| wrSlot | input | 3 | Slot of the store write |
| wrData | input | 64 | Command to be written |
| cmdValid | output | 1 | Command issued this cycle |
| cmdWord | output | 64 | Current command word |
| cmdSlot | output | 3 | Slot of the current command |
| seqDone | output | 1 | Sequence finished (one-cycle pulse) |
| noLastErr | output | 1 | Sequence ran out of slots without a final flag |
| busyReject | output | 1 | Start ignored because a sequence is running |

## Verification
Two events can land in the same clock edge: a store write and the fetch of the same entry. The bench provokes this by driving a write to slot 0 of the running recipe in the fetch cycle that follows the start. It expects the old command to be issued in that run and the new command in the run that follows. A second overlap, a start request during an active run, is driven midway through a sequence. The bench checks that `busyReject` rises in that cycle and that the issued sequence still matches the original recipe.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int CMD_W     = 64;
  localparam int NOP_BIT   = 30;
  localparam int IMM_BIT   = 31;
  localparam int LAST_BIT  = 32;
  localparam int STALL_BIT = 33;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRecipe;
    logic fetch;
    logic advance;
  } seqCtlT;

  // decoded view of the held command
  typedef struct packed {
    logic isLast;
    logic isStall;
    logic isNop;
    logic atFinalSlot;
  } cmdFlagsT;
endpackage

// File: rtl/cmdseq_datapath.sv
module cmdseq_datapath
  import cmdseq_pkg::*;
#(
  parameter int RECIPES = 16,
  parameter int SLOTS   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqCtlT                      ctl,
  input  logic [$clog2(RECIPES)-1:0]  startRecipe,
  input  logic                        wrEn,
  input  logic [$clog2(RECIPES)-1:0]  wrRecipe,
  input  logic [$clog2(SLOTS)-1:0]    wrSlot,
  input  logic [CMD_W-1:0]            wrData,
  output logic [CMD_W-1:0]            cmdWord,
  output logic [$clog2(SLOTS)-1:0]    cmdSlot,
  output cmdFlagsT                    flags
);
  localparam int REC_W  = $clog2(RECIPES);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ADDR_W = REC_W + SLOT_W;
  localparam int DEPTH  = RECIPES * SLOTS;

  logic [CMD_W-1:0]  store [DEPTH];
  logic [REC_W-1:0]  recipeQ;
  logic [SLOT_W-1:0] slotQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  // both dimensions are powers of two, so recipe*SLOTS+slot is a concatenation
  assign rdAddr = {recipeQ, slotQ};
  assign wrAddr = {wrRecipe, wrSlot};

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recipeQ <= '0;
      slotQ   <= '0;
      cmdQ    <= '0;
    end else begin
      if (ctl.loadRecipe) begin
        recipeQ <= startRecipe;
        slotQ   <= '0;
      end else if (ctl.advance) begin
        slotQ <= slotQ + 1'b1;
      end
      // old contents are read when a write hits the same entry this edge
      if (ctl.fetch) cmdQ <= store[rdAddr];
    end
  end

  assign cmdWord           = cmdQ;
  assign cmdSlot           = slotQ;
  assign flags.isLast      = cmdQ[LAST_BIT];
  assign flags.isStall     = cmdQ[STALL_BIT];
  assign flags.isNop       = cmdQ[NOP_BIT];
  assign flags.atFinalSlot = (slotQ == SLOT_W'(SLOTS - 1));
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     unitReady,
  input  cmdFlagsT flags,
  output seqCtlT   ctl,
  output logic     cmdValid,
  output logic     seqDone,
  output logic     noLastErr,
  output logic     busyReject,
  output logic     execPhase
);
  seqStateT state, stateNext;
  logic     consume;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign consume    = flags.isNop || !flags.isStall || unitReady;
  assign busyReject = startReq && (state != ST_IDLE);
  assign execPhase  = (state == ST_EXEC);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    cmdValid  = 1'b0;
    seqDone   = 1'b0;
    noLastErr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.loadRecipe = 1'b1;
          stateNext      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ctl.fetch = 1'b1;
        stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        if (consume) begin
          cmdValid = !flags.isNop;
          if (flags.isLast) begin
            seqDone   = 1'b1;
            stateNext = ST_IDLE;
          end else if (flags.atFinalSlot) begin
            seqDone   = 1'b1;
            noLastErr = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.advance = 1'b1;
            stateNext   = ST_FETCH;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/recipe_cmd_sequencer.sv
module recipe_cmd_sequencer
  import cmdseq_pkg::*;
#(
  parameter int RECIPES = 16,
  parameter int SLOTS   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startReq,
  input  logic [$clog2(RECIPES)-1:0] startRecipe,
  input  logic                       unitReady,
  input  logic                       wrEn,
  input  logic [$clog2(RECIPES)-1:0] wrRecipe,
  input  logic [$clog2(SLOTS)-1:0]   wrSlot,
  input  logic [CMD_W-1:0]           wrData,
  output logic                       cmdValid,
  output logic [CMD_W-1:0]           cmdWord,
  output logic [$clog2(SLOTS)-1:0]   cmdSlot,
  output logic                       seqDone,
  output logic                       noLastErr,
  output logic                       busyReject
);
  seqCtlT   ctl;
  cmdFlagsT flags;
  logic     execPhase;

  cmdseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .unitReady  (unitReady),
    .flags      (flags),
    .ctl        (ctl),
    .cmdValid   (cmdValid),
    .seqDone    (seqDone),
    .noLastErr  (noLastErr),
    .busyReject (busyReject),
    .execPhase  (execPhase)
  );

  cmdseq_datapath #(.RECIPES(RECIPES), .SLOTS(SLOTS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .startRecipe (startRecipe),
    .wrEn        (wrEn),
    .wrRecipe    (wrRecipe),
    .wrSlot      (wrSlot),
    .wrData      (wrData),
    .cmdWord     (cmdWord),
    .cmdSlot     (cmdSlot),
    .flags       (flags)
  );
endmodule

// File: rtl/recipe_cmd_sequencer_chk.sv
module recipe_cmd_sequencer_chk
  import cmdseq_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     startReq,
  input logic                     unitReady,
  input logic                     cmdValid,
  input logic [CMD_W-1:0]         cmdWord,
  input logic [$clog2(SLOTS)-1:0] cmdSlot,
  input logic                     seqDone,
  input logic                     noLastErr,
  input logic                     busyReject,
  input logic                     execPhase
);
  localparam int SLOT_W = $clog2(SLOTS);

  assert_accepted_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busyReject) |=> (cmdSlot == '0 && !cmdValid && !execPhase));

  assert_skip_never_issued_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !cmdWord[NOP_BIT]);

  assert_stall_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (execPhase && cmdWord[STALL_BIT] && !unitReady) |-> !cmdValid);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (execPhase && cmdWord[STALL_BIT] && !cmdWord[NOP_BIT] && !unitReady)
      |=> (execPhase && $stable(cmdWord) && $stable(cmdSlot)));

  assert_done_on_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !noLastErr) |-> (execPhase && cmdWord[LAST_BIT]));

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> (!execPhase && !cmdValid && !seqDone));

  assert_err_final_slot_R7: assert property (@(posedge clk) disable iff (!rstN)
    noLastErr |-> (seqDone && !cmdWord[LAST_BIT] && cmdSlot == SLOT_W'(SLOTS - 1)));

  assert_reject_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyReject |-> startReq);
endmodule

bind recipe_cmd_sequencer recipe_cmd_sequencer_chk #(.SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .unitReady  (unitReady),
  .cmdValid   (cmdValid),
  .cmdWord    (cmdWord),
  .cmdSlot    (cmdSlot),
  .seqDone    (seqDone),
  .noLastErr  (noLastErr),
  .busyReject (busyReject),
  .execPhase  (execPhase)
);

// File: tb/sim_recipe_cmd_sequencer.sv
`timescale 1ns/100ps
module sim_recipe_cmd_sequencer;
  localparam int RECIPES = 16;
  localparam int SLOTS   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [3:0]  startRecipe = '0;
  logic        unitReady = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrRecipe = '0;
  logic [2:0]  wrSlot = '0;
  logic [63:0] wrData = '0;
  logic        cmdValid;
  logic [63:0] cmdWord;
  logic [2:0]  cmdSlot;
  logic        seqDone;
  logic        noLastErr;
  logic        busyReject;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [63:0] model [RECIPES][SLOTS];

  always #2 clk = ~clk;

  recipe_cmd_sequencer #(.RECIPES(RECIPES), .SLOTS(SLOTS)) u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bits: 33 stall, 32 last, 31 imm, 30 skip
  function automatic logic [63:0] mk(bit last, bit stall, bit nop, bit imm);
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    w[33] = stall; w[32] = last; w[31] = imm; w[30] = nop;
    return w;
  endfunction

  task automatic writeCmd(int r, int s, logic [63:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrRecipe = 4'(r); wrSlot = 3'(s); wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
    model[r][s] = w;
  endtask

  // runs recipe r; pokeIter>=0 drives a rejected start in that loop pass;
  // doCollide drives a write of newW to (r,0) in the fetch cycle of slot 0
  task automatic runRecipe(int r, int readyPct, int pokeIter, bit doCollide,
                           logic [63:0] newW, output int doneIter);
    logic [63:0] expW [SLOTS];
    int expS [SLOTS];
    int expN = 0;
    bit expErr = 1'b1;
    int got = 0;
    bit fin = 0;
    bit errSeen = 0;
    int cyc = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!model[r][s][30]) begin expW[expN] = model[r][s]; expS[expN] = s; expN++; end
      if (model[r][s][32]) begin expErr = 1'b0; break; end
    end
    @(negedge clk);
    startReq = 1'b1; startRecipe = 4'(r);
    @(negedge clk);
    startReq = 1'b0;
    doneIter = -1;
    while (!fin && cyc < 400) begin
      unitReady = ($urandom_range(99) < readyPct);
      if (doCollide && cyc == 0) begin
        wrEn = 1'b1; wrRecipe = 4'(r); wrSlot = 3'd0; wrData = newW;
      end
      if (cyc == pokeIter) begin
        startReq = 1'b1; startRecipe = 4'(r ^ 1);
      end
      #0.5;
      if (cyc == pokeIter) check("R8 busyReject", 64'(busyReject), 64'd1);
      if (cmdValid) begin
        if (got < expN) begin
          check("R3 word", cmdWord, expW[got]);
          check("R3 slot", 64'(cmdSlot), 64'(expS[got]));
        end
        got++;
      end
      if (seqDone) begin fin = 1; errSeen = noLastErr; doneIter = cyc; end
      cyc++;
      @(negedge clk);
      wrEn = 1'b0; startReq = 1'b0;
    end
    if (doCollide) model[r][0] = newW;
    check("R2 issue count", 64'(got), 64'(expN));
    check("R7 error flag", 64'(errSeen), 64'(expErr));
    check("R6 finished", 64'(fin), 64'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int di;
    logic [63:0] w0;
    logic [63:0] w1;
    $urandom(32'd1234);
    repeat (3) @(negedge clk);
    #0.5;
    check("R1 cmdValid", 64'(cmdValid), 64'd0);
    check("R1 seqDone", 64'(seqDone), 64'd0);
    check("R1 noLastErr", 64'(noLastErr), 64'd0);
    check("R1 busyReject", 64'(busyReject), 64'd0);
    rstN = 1'b1;
    for (int r = 0; r < RECIPES; r++)
      for (int s = 0; s < SLOTS; s++) writeCmd(r, s, mk(1, 0, 1, 0));

    // R2/R3: plain recipe, final flag at slot 2, immediate bit passes through
    writeCmd(0, 0, mk(0, 0, 0, 1));
    writeCmd(0, 1, mk(0, 0, 0, 0));
    writeCmd(0, 2, mk(1, 0, 0, 1));
    runRecipe(0, 100, -1, 0, '0, di);
    check("R2 first exec cycle timing", 64'(di), 64'd5);

    // R6: unused-unit marker at slot 0 ends at once
    runRecipe(1, 100, -1, 0, '0, di);
    check("R6 marker ends first exec", 64'(di), 64'd1);

    // R4: skipped commands, including a skip with the stall bit set
    writeCmd(2, 0, mk(0, 0, 1, 0));
    writeCmd(2, 1, mk(0, 1, 1, 0));
    writeCmd(2, 2, mk(0, 0, 0, 0));
    writeCmd(2, 3, mk(1, 0, 1, 0));
    runRecipe(2, 0, -1, 0, '0, di);

    // R7: no final flag anywhere
    for (int s = 0; s < SLOTS; s++) writeCmd(3, s, mk(0, 0, s[0], 0));
    runRecipe(3, 100, -1, 0, '0, di);

    // R5: stall hold, directed
    writeCmd(4, 0, mk(1, 1, 0, 0));
    @(negedge clk); startReq = 1'b1; startRecipe = 4'd4; unitReady = 1'b0;
    @(negedge clk); startReq = 1'b0;
    @(negedge clk); #0.5;
    w0 = cmdWord;
    check("R5 word at wait start", w0, model[4][0]);
    for (int i = 0; i < 4; i++) begin
      check("R5 held no issue", 64'(cmdValid), 64'd0);
      check("R5 word steady", cmdWord, w0);
      check("R5 slot steady", 64'(cmdSlot), 64'd0);
      @(negedge clk); #0.5;
    end
    unitReady = 1'b1; #0.5;
    check("R5 issue on ready", 64'(cmdValid), 64'd1);
    check("R6 done with last", 64'(seqDone), 64'd1);
    @(negedge clk);

    // R8: start during a running sequence
    for (int s = 0; s < 4; s++) writeCmd(5, s, mk(s == 3, 0, 0, 0));
    runRecipe(5, 100, 2, 0, '0, di);

    // R9: write and fetch of the same entry in one cycle
    writeCmd(7, 0, mk(1, 0, 0, 0));
    w1 = mk(1, 0, 0, 1);
    runRecipe(7, 100, -1, 1, w1, di);
    runRecipe(7, 100, -1, 0, '0, di);

    // random recipes with random readiness
    for (int round = 0; round < 6; round++) begin
      for (int r = 8; r < RECIPES; r++) begin
        for (int s = 0; s < SLOTS; s++)
          writeCmd(r, s, mk($urandom_range(99) < 20, $urandom_range(99) < 30,
                            $urandom_range(99) < 25, $urandom_range(1)));
        runRecipe(r, 60, (round == 2) ? 3 : -1, 0, '0, di);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule